// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a logical address when the translation cache misses. It takes a 32-bit logical address and splits it, for 1 KB pages, into three fields. The top 12 bits are an outer index, the next 10 bits are an inner index, and the low 10 bits are the byte offset. The walker first reads one 4-byte entry from the outer table, at the table base plus four times the outer index. If that entry is present, it uses the entry's upper bits as the base of an inner table and reads the entry that the inner index picks. The leaf entry gives the physical frame and a writable flag. If a step fails, the walker reports a page fault with a code that names the step.

Before any memory access, the outer index is compared with a table-length bound. An index at or beyond the bound faults at once. Memory is reached through a read port that allows only one read in flight. A read is requested, then granted, and its data comes back later with a valid strobe. The walker takes a new walk only while idle. Each walk ends with a result strobe that lasts one cycle.

Entry layout, used at both levels: bits 31:10 hold the frame number or the base of the next table, bit 1 is the writable flag, and bit 0 is the present flag. Fault codes: 0 means no fault, 1 means the outer index is out of bounds, 2 means the outer entry is not present, and 3 means the leaf entry is not present.

Top module: `ptw_top`

## Requirements
- R1: The first read of an accepted walk goes to `tableBase + 4*vaddr[31:20]`. `tableBase` is the value captured when the walk is accepted.
- R2: The second read goes to `{outerEntry[31:10], 10'b0} + 4*vaddr[19:10]`.
- R3: If `vaddr[31:20] >= tableLen`, the walk ends with fault code 1 and makes no memory request. An index of `tableLen-1` is legal.
- R4: If outer entry bit 0 is 0, the walk ends with fault code 2 after exactly one memory read.
- R5: If leaf entry bit 0 is 0, the walk ends with fault code 3 after exactly two memory reads.
- R6: A successful walk ends with fault code 0 and `resFault` low. It returns `resFrame = leaf[31:10]`, `resWritable = leaf[1]` and `resPaddr = {leaf[31:10], vaddr[9:0]}`.
- R7: Only one read is in flight at a time. `memReq` is low from the grant until the read data returns. While a request waits for its grant, `memReq` and `memAddr` stay constant.
- R8: `walkReady` is high only while the walker is idle. A walk is accepted on a cycle where `walkReq` and `walkReady` are both high. Requests made while the walker is busy are ignored and do not change the result of the walk in progress.
- R9: `resValid` is high for exactly one cycle for each accepted walk. The walker is ready again on the next cycle.
- R10: After reset, `walkReady` is high and `memReq` and `resValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Start a walk |
| walkVaddr | input | 32 | Logical address to translate |
| tableBase | input | 32 | Byte address of the outer table |
| tableLen | input | 13 | Number of legal outer indices |
| walkReady | output | 1 | Walker is idle and can accept a walk |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Read byte address |
| memGnt | input | 1 | Request granted |
| memRvalid | input | 1 | Read data is valid |
| memRdata | input | 32 | Read data (one entry) |
| resValid | output | 1 | Result strobe, one cycle |
| resFault | output | 1 | Walk ended in a page fault |
| resFaultCode | output | 2 | 0 none, 1 bound, 2 outer not present, 3 leaf not present |
| resFrame | output | 22 | Physical frame number |
| resWritable | output | 1 | Leaf writable flag |
| resPaddr | output | 32 | Physical byte address |

## Verification
The bench's memory model computes every entry from its address. Outer entries are absent for every index equal to 3 mod 5. Leaf entries are absent where the sum of the two indices is a multiple of 7. Frames and writable flags follow a simple formula.

A sweep over 48 outer indices and a spread of inner indices, with the bound set to 40, tries all four outcomes. It also tells the legal index just below the bound apart from the first illegal one. The addresses of both reads are compared directly. A wrong split or a bad table base sends a read outside the model, and the model returns a recognisable junk entry.

Grant and data latencies change from walk to walk, to exercise the single-read handshake. Extra cases cover a bound of zero, a full-size bound with index 4095, a table base that is not 4 KB aligned, and a stream of requests made while the walker is busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PRESENT_BIT = 0;
  localparam int WRITE_BIT   = 1;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUND  = 2'd1,
    FLT_OUTER  = 2'd2,
    FLT_LEAF   = 2'd3
  } faultCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptWalk;
    logic takeOuter;
    logic takeLeaf;
    logic selInner;
  } ctrlStrobes_t;

endpackage

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 10,
  parameter int INW  = 10,
  localparam int OUTW = AW - OFFW - INW,
  localparam int FRW  = AW - OFFW
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [AW-1:0]   walkVaddr,
  input  logic [AW-1:0]   tableBase,
  input  logic [OUTW:0]   tableLen,
  input  logic [AW-1:0]   memRdata,
  output logic            boundOk,
  output logic [AW-1:0]   memAddr,
  output logic [FRW-1:0]  resFrame,
  output logic            resWritable,
  output logic [AW-1:0]   resPaddr
);

  logic [AW-1:0]  vaReg;
  logic [AW-1:0]  baseReg;
  logic [FRW-1:0] innerBase;
  logic [FRW-1:0] frameReg;
  logic           writeReg;

  logic [OUTW-1:0] outerIdx;
  logic [INW-1:0]  innerIdx;
  logic [AW-1:0]   outerAddr;
  logic [AW-1:0]   innerAddr;
  logic            unusedEntryBits;

  assign outerIdx  = vaReg[AW-1 -: OUTW];
  assign innerIdx  = vaReg[OFFW +: INW];
  assign outerAddr = baseReg + AW'({outerIdx, 2'b00});
  assign innerAddr = {innerBase, {OFFW{1'b0}}} + AW'({innerIdx, 2'b00});
  assign memAddr   = strobes.selInner ? innerAddr : outerAddr;

  assign boundOk = {1'b0, walkVaddr[AW-1 -: OUTW]} < tableLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      baseReg   <= '0;
      innerBase <= '0;
      frameReg  <= '0;
      writeReg  <= 1'b0;
    end else begin
      if (strobes.acceptWalk) begin
        vaReg    <= walkVaddr;
        baseReg  <= tableBase;
        frameReg <= '0;
        writeReg <= 1'b0;
      end
      if (strobes.takeOuter) innerBase <= memRdata[AW-1:OFFW];
      if (strobes.takeLeaf) begin
        frameReg <= memRdata[AW-1:OFFW];
        writeReg <= memRdata[WRITE_BIT];
      end
    end
  end

  assign resFrame    = frameReg;
  assign resWritable = writeReg;
  assign resPaddr    = {frameReg, vaReg[OFFW-1:0]};

  assign unusedEntryBits = ^{memRdata[OFFW-1:WRITE_BIT+1], memRdata[PRESENT_BIT]};

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          walkReq,
  input  logic          boundOk,
  input  logic          memGnt,
  input  logic          memRvalid,
  input  logic          entryPresent,
  output logic          walkReady,
  output logic          memReq,
  output ctrlStrobes_t  strobes,
  output logic          resValid,
  output logic          resFault,
  output logic [1:0]    resFaultCode
);

  walkState_e state, stateNext;
  faultCode_e code, codeNext;
  logic       pending, pendingNext;
  logic       reading, dataIn;

  assign reading = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign dataIn  = reading && pending && memRvalid;

  always_comb begin
    stateNext   = state;
    codeNext    = code;
    pendingNext = pending;
    strobes     = '0;
    strobes.selInner = (state == ST_RD_INNER);

    if (reading && !pending && memGnt) pendingNext = 1'b1;

    case (state)
      ST_IDLE: begin
        if (walkReq) begin
          strobes.acceptWalk = 1'b1;
          pendingNext = 1'b0;
          if (boundOk) begin
            stateNext = ST_RD_OUTER;
            codeNext  = FLT_NONE;
          end else begin
            stateNext = ST_FAULT;
            codeNext  = FLT_BOUND;
          end
        end
      end
      ST_RD_OUTER: begin
        if (dataIn) begin
          pendingNext = 1'b0;
          if (entryPresent) begin
            strobes.takeOuter = 1'b1;
            stateNext = ST_RD_INNER;
          end else begin
            stateNext = ST_FAULT;
            codeNext  = FLT_OUTER;
          end
        end
      end
      ST_RD_INNER: begin
        if (dataIn) begin
          pendingNext = 1'b0;
          if (entryPresent) begin
            strobes.takeLeaf = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_FAULT;
            codeNext  = FLT_LEAF;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      code    <= FLT_NONE;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      code    <= codeNext;
      pending <= pendingNext;
    end
  end

  assign walkReady    = (state == ST_IDLE);
  assign memReq       = reading && !pending;
  assign resValid     = (state == ST_DONE) || (state == ST_FAULT);
  assign resFault     = (state == ST_FAULT);
  assign resFaultCode = code;

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 10,
  parameter int INW  = 10,
  localparam int OUTW = AW - OFFW - INW,
  localparam int FRW  = AW - OFFW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            walkReq,
  input  logic [AW-1:0]   walkVaddr,
  input  logic [AW-1:0]   tableBase,
  input  logic [OUTW:0]   tableLen,
  output logic            walkReady,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  input  logic            memGnt,
  input  logic            memRvalid,
  input  logic [AW-1:0]   memRdata,
  output logic            resValid,
  output logic            resFault,
  output logic [1:0]      resFaultCode,
  output logic [FRW-1:0]  resFrame,
  output logic            resWritable,
  output logic [AW-1:0]   resPaddr
);

  ctrlStrobes_t strobes;
  logic         boundOk;

  ptw_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .walkReq      (walkReq),
    .boundOk      (boundOk),
    .memGnt       (memGnt),
    .memRvalid    (memRvalid),
    .entryPresent (memRdata[PRESENT_BIT]),
    .walkReady    (walkReady),
    .memReq       (memReq),
    .strobes      (strobes),
    .resValid     (resValid),
    .resFault     (resFault),
    .resFaultCode (resFaultCode)
  );

  ptw_dpath #(.AW(AW), .OFFW(OFFW), .INW(INW)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .walkVaddr   (walkVaddr),
    .tableBase   (tableBase),
    .tableLen    (tableLen),
    .memRdata    (memRdata),
    .boundOk     (boundOk),
    .memAddr     (memAddr),
    .resFrame    (resFrame),
    .resWritable (resWritable),
    .resPaddr    (resPaddr)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          walkReq,
  input logic          walkReady,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic          memGnt,
  input logic          memRvalid,
  input logic          resValid,
  input logic [1:0]    resFaultCode
);

  logic       inFlight;
  logic [1:0] grants;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      grants   <= '0;
    end else begin
      if (memReq && memGnt) inFlight <= 1'b1;
      else if (memRvalid)   inFlight <= 1'b0;
      if (walkReq && walkReady)   grants <= '0;
      else if (memReq && memGnt)  grants <= grants + 2'd1;
    end
  end

  // R7: one read in flight, request held until granted
  a_r7_no_req_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inFlight);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr));
  // R3: bound fault makes no read
  a_r3_no_read_on_bound: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resFaultCode == 2'd1 |-> grants == 2'd0);
  // R4: outer fault after one read
  a_r4_one_read: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resFaultCode == 2'd2 |-> grants == 2'd1);
  // R5 and R6: leaf outcome after two reads
  a_r5_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (resFaultCode == 2'd3 || resFaultCode == 2'd0) |-> grants == 2'd2);
  // R8: busy after accept, not ready while reporting
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkReady |=> !walkReady);
  a_r8_not_ready_on_result: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !walkReady);
  // R9: single-cycle result then ready
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid && walkReady);

endmodule

bind ptw_top ptw_checker #(.AW(AW)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .walkReq      (walkReq),
  .walkReady    (walkReady),
  .memReq       (memReq),
  .memAddr      (memAddr),
  .memGnt       (memGnt),
  .memRvalid    (memRvalid),
  .resValid     (resValid),
  .resFaultCode (resFaultCode)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkReq = 1'b0;
  logic [31:0] walkVaddr = '0;
  logic [31:0] tableBase = 32'h0010_0000;
  logic [12:0] tableLen = 13'd40;
  logic        walkReady, memReq, resValid, resFault, resWritable;
  logic [31:0] memAddr, resPaddr;
  logic        memGnt = 1'b0;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic [1:0]  resFaultCode;
  logic [21:0] resFrame;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // memory model state
  int          gntLat = 0, rdLat = 1, gWait = 0, rvCnt = 0, grantCnt = 0;
  logic [31:0] capAddr = '0, addr0 = '0, addr1 = '0;

  localparam logic [31:0] INNER_REGION = 32'h0800_0000;

  always #5 clk = ~clk;

  ptw_top dut_i (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .walkVaddr(walkVaddr),
    .tableBase(tableBase), .tableLen(tableLen), .walkReady(walkReady),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt), .memRvalid(memRvalid),
    .memRdata(memRdata), .resValid(resValid), .resFault(resFault),
    .resFaultCode(resFaultCode), .resFrame(resFrame), .resWritable(resWritable),
    .resPaddr(resPaddr)
  );

  function automatic logic [21:0] leafFrame(int o, int i);
    return 22'((o * 7 + i * 13 + 5) & 32'h3F_FFFF);
  endfunction

  function automatic logic [31:0] memModel(logic [31:0] a);
    int o, i;
    if (a >= tableBase && a < tableBase + 32'h4000 && a[1:0] == 2'b00) begin
      o = int'((a - tableBase) >> 2);
      return {10'((INNER_REGION + 32'(o) * 32'h1000) >> 10) == 10'h0 ?
              22'((INNER_REGION + 32'(o) * 32'h1000) >> 10) :
              22'((INNER_REGION + 32'(o) * 32'h1000) >> 10),
              8'h00, 1'b0, (o % 5) != 3};
    end
    if (a >= INNER_REGION && a < INNER_REGION + 32'h0100_0000 && a[1:0] == 2'b00) begin
      o = int'((a - INNER_REGION) >> 12);
      i = int'((a >> 2) & 32'h3FF);
      return {leafFrame(o, i), 8'h00, (i % 3) == 0, ((o + i) % 7) != 0};
    end
    return 32'hDEAD_BEEF;
  endfunction

  // memory port model, driven away from the active edge
  always @(negedge clk) begin
    memRvalid = 1'b0;
    if (rvCnt > 0) begin
      rvCnt--;
      if (rvCnt == 0) begin
        memRvalid = 1'b1;
        memRdata  = memModel(capAddr);
      end
    end
    if (memGnt) begin
      memGnt = 1'b0;
      rvCnt  = rdLat;
    end else if (memReq && rvCnt == 0 && !memRvalid) begin
      if (gWait >= gntLat) begin
        memGnt  = 1'b1;
        capAddr = memAddr;
        if (grantCnt == 0) addr0 = memAddr;
        if (grantCnt == 1) addr1 = memAddr;
        grantCnt++;
        gWait = 0;
      end else gWait++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] va, input bit pokeBusy);
    int o, i, guard;
    logic [1:0]  expCode;
    logic [21:0] expFrame;
    logic        expWr;
    o = int'(va[31:20]);
    i = int'(va[19:10]);
    grantCnt = 0;
    gntLat = (o + i) % 3;
    rdLat  = 1 + (o % 3);
    walkReq = 1'b1;
    walkVaddr = va;
    @(posedge clk);
    @(negedge clk);
    walkReq = 1'b0;
    check(walkReady == 1'b0 || resValid, "R8 busy after accept", 32'(walkReady), 32'd0);
    guard = 0;
    while (!resValid && guard < 100) begin
      if (pokeBusy) begin
        walkReq = 1'b1;
        walkVaddr = ~va;
      end
      @(negedge clk);
      guard++;
    end
    walkReq = 1'b0;
    walkVaddr = va;
    check(resValid, "R9 result arrives", 32'(resValid), 32'd1);

    expFrame = '0;
    expWr = 1'b0;
    if (32'(o) >= 32'(tableLen)) expCode = 2'd1;
    else if (o % 5 == 3) expCode = 2'd2;
    else if ((o + i) % 7 == 0) expCode = 2'd3;
    else begin
      expCode = 2'd0;
      expFrame = leafFrame(o, i);
      expWr = (i % 3) == 0;
    end

    case (expCode)
      2'd1: check(grantCnt == 0, "R3 no read on bound fault", 32'(grantCnt), 32'd0);
      2'd2: check(grantCnt == 1, "R4 one read on outer fault", 32'(grantCnt), 32'd1);
      default: check(grantCnt == 2, "R5 two reads to leaf", 32'(grantCnt), 32'd2);
    endcase
    if (expCode != 2'd1)
      check(addr0 == tableBase + 32'(o) * 4, "R1 outer address", addr0, tableBase + 32'(o) * 4);
    if (expCode == 2'd0 || expCode == 2'd3)
      check(addr1 == INNER_REGION + 32'(o) * 32'h1000 + 32'(i) * 4, "R2 inner address",
            addr1, INNER_REGION + 32'(o) * 32'h1000 + 32'(i) * 4);
    check(resFaultCode == expCode, "R3 R4 R5 fault code", 32'(resFaultCode), 32'(expCode));
    check(resFault == (expCode != 2'd0), "R6 fault flag", 32'(resFault), 32'(expCode != 2'd0));
    if (expCode == 2'd0) begin
      check(resFrame == expFrame, "R6 frame", 32'(resFrame), 32'(expFrame));
      check(resWritable == expWr, "R6 writable", 32'(resWritable), 32'(expWr));
      check(resPaddr == {expFrame, va[9:0]}, "R6 physical address", resPaddr, {expFrame, va[9:0]});
    end
    @(negedge clk);
    check(!resValid && walkReady, "R9 one-cycle result then ready",
          {30'd0, resValid, walkReady}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(walkReady && !memReq && !resValid, "R10 reset state",
          {29'd0, walkReady, memReq, resValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(walkReady && !memReq && !resValid, "R10 idle after reset",
          {29'd0, walkReady, memReq, resValid}, 32'h4);

    // main sweep, bound 40
    for (int o = 0; o < 48; o++) begin
      for (int i = 0; i < 1024; i += 97)
        runWalk({12'(o), 10'(i), 10'(o * 37 + i)}, 1'b0);
      runWalk({12'(o), 10'd1023, 10'h3FF}, 1'b0);
    end

    // R3 boundary: index just below and at the bound
    tableLen = 13'd17;
    runWalk({12'd16, 10'd1, 10'd5}, 1'b0);
    runWalk({12'd17, 10'd1, 10'd5}, 1'b0);
    tableLen = 13'd0;
    runWalk({12'd0, 10'd2, 10'd0}, 1'b0);
    tableLen = 13'd4096;
    runWalk({12'd4095, 10'd4, 10'h155}, 1'b0);
    runWalk({12'd4094, 10'd9, 10'h2AA}, 1'b0);

    // R1 with a base that is not 4 KB aligned
    tableBase = 32'h0020_0400;
    for (int o = 0; o < 12; o++) runWalk({12'(o * 300), 10'(o * 61), 10'(o)}, 1'b0);

    // R8: requests while busy are ignored
    tableBase = 32'h0010_0000;
    tableLen = 13'd40;
    for (int o = 0; o < 10; o++) runWalk({12'(o), 10'(o * 11 + 1), 10'h0F0}, 1'b1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule